// File: doc/BRIEF.md
# S/PDIF Channel-Status and Validity Generator

This block holds the 16-bit S/PDIF transmit control word and turns it into the per-frame side bits that a biphase-mark transmitter needs. A host writes the word through a write strobe and a 16-bit data bus, and can read it back at any time. The transmitter raises `bit_req` once per frame and presents the frame's position (0 to 191) in the channel-status block. On the next clock edge the block presents the channel-status bit for that frame, which goes into both subframes of the frame. It also presents the validity bit, which goes into subframe bit 28.

The transmit enable has an interlock. While the external `mode_lock` input is high (the serial port has claimed the shared output pin for another use), the enable cannot be set and reads back as zero. A stored enable is also cleared by the lock. The fields that feed one 192-frame block are captured into a shadow copy at frame 0. A host write made partway through a block therefore cannot mix two configurations inside that block.

Top module: `spdif_cs_gen`

## Requirements
- R1: After a synchronous reset the control word reads 0000h, and `tx_en`, `cs_bit` and `v_bit` are 0.
- R2: On an edge with `host_wr` high the word is stored. `host_rdata` shows it with this layout: 15 enable, 14 validity, 13 always 0, 12 rate flag, 11 generation status, 10..4 category bits 6..0, 3 emphasis, 2 copy permit, 1 non-audio, 0 professional.
- R3: While `mode_lock` is high, a write of 1 to bit 15 leaves the enable at 0, and `host_rdata[15]` reads 0.
- R4: If `mode_lock` is high while the stored enable is 1, the enable is 0 after the next edge and stays 0 once `mode_lock` falls.
- R5: `tx_en` is 1 exactly when the stored enable is 1 and `mode_lock` is low.
- R6: `cs_bit` and `v_bit` update on the edge where `bit_req` is high and hold their values while `bit_req` is low.
- R7: `v_bit` equals the validity field (bit 14) of the configuration in use for the current block.
- R8: Channel-status bits 0, 1, 2 and 3 carry the professional, non-audio, copy-permit and emphasis fields. Bits 8 to 14 carry category bits 0 to 6. Bit 15 carries the generation status.
- R9: Channel-status bit 25 is the inverse of the rate flag. A flag of 0 (48 kHz) gives 1.
- R10: Channel-status positions 4 to 7, 16 to 24 and 26 to 191 give 0. So does any index from 192 upward.
- R11: A request at frame 0 captures the stored word as it was before that edge. Frame 0 and frames 1 to 191 of that block use the captured copy. A write made in the same cycle or later takes effect at the next frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Control word read-back |
| mode_lock | input | 1 | Pin claimed by the serial port; blocks the enable |
| bit_req | input | 1 | Frame request from the transmitter |
| frame_idx | input | 8 | Frame position within the channel-status block |
| tx_en | output | 1 | Effective transmit enable |
| cs_bit | output | 1 | Channel-status bit for the requested frame |
| v_bit | output | 1 | Validity bit for subframe bit 28 |

## Verification
A host write and the frame-0 capture of the shadow copy can fall on the same clock edge. The bench drives `host_wr` with a new word in the same cycle as a frame-0 request. It then expects frame 0 and frame 1 to reflect the old word, and the following frame 0 to reflect the new one. A write of 1 to the enable can also meet a high `mode_lock` in the same cycle. Here the read-back and `tx_en` must stay 0, both while the lock is held and after it is released.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
  localparam int CTRL_W   = 16;
  localparam int CAT_W    = 7;
  localparam int CS_LOW_W = 32;
  localparam int CS_PRO     = 0;
  localparam int CS_NONAUD  = 1;
  localparam int CS_COPY    = 2;
  localparam int CS_EMPH    = 3;
  localparam int CS_CAT_LO  = 8;
  localparam int CS_GEN     = 15;
  localparam int CS_RATE    = 25;

  typedef struct packed {
    logic             en;
    logic             valid_n;
    logic             rsvd;
    logic             rate441;
    logic             gen;
    logic [CAT_W-1:0] cat;
    logic             emph;
    logic             copy_ok;
    logic             non_audio;
    logic             pro;
  } ctrl_t;
endpackage

// File: rtl/spdif_cs_regs.sv
module spdif_cs_regs
  import spdif_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              lock,
  output ctrl_t             ctrl_q,
  output logic [CTRL_W-1:0] rdata,
  output logic              en_eff
);
  ctrl_t wr_c;
  ctrl_t ctrl_d;

  assign wr_c = ctrl_t'(wdata);

  always_comb begin
    ctrl_d      = wr ? wr_c : ctrl_q;
    // the lock both blocks a new set and clears a stored enable
    ctrl_d.en   = ctrl_d.en & ~lock;
    ctrl_d.rsvd = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  assign en_eff = ctrl_q.en & ~lock;

  always_comb begin
    rdata     = CTRL_W'(ctrl_q);
    rdata[15] = en_eff;
    rdata[13] = 1'b0;
  end
endmodule

// File: rtl/spdif_cs_mux.sv
module spdif_cs_mux
  import spdif_cs_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int FRAMES = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  ctrl_t            live,
  output logic             cs_bit,
  output logic             v_bit
);
  localparam int LOW_IW = $clog2(CS_LOW_W);
  localparam logic [IDX_W:0] FRAMES_W = FRAMES[IDX_W:0];

  ctrl_t               shadow_q;
  ctrl_t               src;
  logic [CS_LOW_W-1:0] low_map;
  logic                is_start;
  logic                in_low;
  logic                in_block;
  logic                sel_bit;

  assign is_start = (idx == '0);
  assign src      = is_start ? live : shadow_q;
  assign in_low   = (idx[IDX_W-1:LOW_IW] == '0);
  assign in_block = ({1'b0, idx} < FRAMES_W);

  always_comb begin
    low_map            = '0;
    low_map[CS_PRO]    = src.pro;
    low_map[CS_NONAUD] = src.non_audio;
    low_map[CS_COPY]   = src.copy_ok;
    low_map[CS_EMPH]   = src.emph;
    for (int k = 0; k < CAT_W; k++) low_map[CS_CAT_LO+k] = src.cat[k];
    low_map[CS_GEN]    = src.gen;
    low_map[CS_RATE]   = ~src.rate441;
  end

  assign sel_bit = in_block & in_low & low_map[idx[LOW_IW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      cs_bit   <= 1'b0;
      v_bit    <= 1'b0;
    end else if (req) begin
      if (is_start) shadow_q <= live;
      cs_bit <= sel_bit;
      v_bit  <= src.valid_n;
    end
  end
endmodule

// File: rtl/spdif_cs_gen.sv
module spdif_cs_gen
  import spdif_cs_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [CTRL_W-1:0] host_rdata,
  input  logic              mode_lock,
  input  logic              bit_req,
  input  logic [IDX_W-1:0]  frame_idx,
  output logic              tx_en,
  output logic              cs_bit,
  output logic              v_bit
);
  ctrl_t ctrl_q;

  spdif_cs_regs u_regs (
    .clk(clk), .rst(rst), .wr(host_wr), .wdata(host_wdata), .lock(mode_lock),
    .ctrl_q(ctrl_q), .rdata(host_rdata), .en_eff(tx_en)
  );

  spdif_cs_mux #(.IDX_W(IDX_W), .FRAMES(FRAMES)) u_mux (
    .clk(clk), .rst(rst), .req(bit_req), .idx(frame_idx), .live(ctrl_q),
    .cs_bit(cs_bit), .v_bit(v_bit)
  );
endmodule

// File: rtl/spdif_cs_gen_chk.sv
module spdif_cs_gen_chk #(
  parameter int IDX_W  = 8,
  parameter int FRAMES = 192
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic [15:0]      host_rdata,
  input logic             mode_lock,
  input logic             bit_req,
  input logic [IDX_W-1:0] frame_idx,
  input logic             tx_en,
  input logic             cs_bit,
  input logic             v_bit
);
  localparam logic [IDX_W:0] FRAMES_W = FRAMES[IDX_W:0];

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    host_rdata[13] == 1'b0);
  assert_lock_read_R3: assert property (@(posedge clk) disable iff (rst)
    mode_lock |-> !host_rdata[15]);
  assert_lock_write_R3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && mode_lock) |=> !host_rdata[15]);
  assert_lock_clears_R4: assert property (@(posedge clk) disable iff (rst)
    mode_lock |=> !tx_en);
  assert_txen_lock_R5: assert property (@(posedge clk) disable iff (rst)
    mode_lock |-> !tx_en);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_req |=> ($stable(cs_bit) && $stable(v_bit)));
  assert_out_of_block_R10: assert property (@(posedge clk) disable iff (rst)
    (bit_req && ({1'b0, frame_idx} >= FRAMES_W)) |=> !cs_bit);
  assert_gap_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bit_req && frame_idx >= IDX_W'(16) && frame_idx <= IDX_W'(24)) |=> !cs_bit);
endmodule

bind spdif_cs_gen spdif_cs_gen_chk #(.IDX_W(IDX_W), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rdata(host_rdata),
  .mode_lock(mode_lock), .bit_req(bit_req), .frame_idx(frame_idx),
  .tx_en(tx_en), .cs_bit(cs_bit), .v_bit(v_bit)
);

// File: tb/spdif_cs_gen_tb.sv
module spdif_cs_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        mode_lock = 1'b0;
  logic        bit_req = 1'b0;
  logic [7:0]  frame_idx = '0;
  logic        tx_en, cs_bit, v_bit;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  spdif_cs_gen u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mode_lock(mode_lock), .bit_req(bit_req),
    .frame_idx(frame_idx), .tx_en(tx_en), .cs_bit(cs_bit), .v_bit(v_bit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_cs(input logic [15:0] w, input int i);
    if (i == 0) return w[0];
    if (i == 1) return w[1];
    if (i == 2) return w[2];
    if (i == 3) return w[3];
    if (i >= 8 && i <= 14) return w[i-4];
    if (i == 15) return w[11];
    if (i == 25) return ~w[12];
    return 1'b0;
  endfunction

  task automatic wr(input logic [15:0] v);
    host_wr = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic req(input int i);
    bit_req = 1'b1; frame_idx = 8'(i);
    @(negedge clk);
    bit_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", host_rdata, 16'h0000);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 cs_bit", cs_bit, 0);
    chk("R1 v_bit", v_bit, 0);
  endtask

  task automatic t_readback;
    wr(16'hFFFF);
    chk("R2 rdata", host_rdata, 16'hDFFF);
    chk("R5 tx_en set", tx_en, 1);
    wr(16'h1A5C);
    chk("R2 rdata pattern", host_rdata, 16'h1A5C);
    chk("R5 tx_en clear", tx_en, 0);
  endtask

  task automatic t_lock;
    mode_lock = 1'b1;
    wr(16'h8000);
    chk("R3 locked write", host_rdata, 16'h0000);
    chk("R3 tx_en", tx_en, 0);
    mode_lock = 1'b0;
    @(negedge clk);
    chk("R3 after release", host_rdata[15], 0);
    wr(16'h8000);
    chk("R5 enable unlocked", tx_en, 1);
    mode_lock = 1'b1;
    #1;
    chk("R5 lock gates tx_en", tx_en, 0);
    chk("R3 readback under lock", host_rdata[15], 0);
    @(negedge clk);
    mode_lock = 1'b0;
    #1;
    chk("R4 cleared after lock", host_rdata[15], 0);
    chk("R4 tx_en stays low", tx_en, 0);
    @(negedge clk);
  endtask

  task automatic t_block(input logic [15:0] w);
    wr(w);
    for (int i = 0; i < 192; i++) begin
      req(i);
      chk("R8 R9 R10 block bit", cs_bit, exp_cs(w, i));
      chk("R7 v_bit", v_bit, w[14]);
    end
  endtask

  task automatic t_edges;
    wr(16'h0000);
    req(0);
    req(25);
    chk("R9 rate 48k gives one", cs_bit, 1);
    bit_req = 1'b0; frame_idx = 8'd4;
    @(negedge clk);
    chk("R6 hold", cs_bit, 1);
    req(200);
    chk("R10 index 200", cs_bit, 0);
    req(25);
    req(255);
    chk("R10 index 255", cs_bit, 0);
  endtask

  task automatic t_shadow;
    logic [15:0] a, b;
    a = 16'h4FF5; b = 16'h100A;
    wr(a);
    req(0);
    chk("R11 frame0 old", cs_bit, a[0]);
    wr(b);
    for (int i = 1; i < 192; i++) begin
      req(i);
      chk("R11 mid-block uses shadow", cs_bit, exp_cs(a, i));
      chk("R11 v from shadow", v_bit, a[14]);
    end
    req(0);
    chk("R11 next frame0 new", cs_bit, b[0]);
    req(1);
    chk("R11 next block new", cs_bit, b[1]);
  endtask

  task automatic t_collide;
    logic [15:0] a, b;
    a = 16'h0003; b = 16'h4000;
    wr(a);
    host_wr = 1'b1; host_wdata = b;
    req(0);
    host_wr = 1'b0;
    chk("R11 same-cycle frame0", cs_bit, 1);
    chk("R11 same-cycle v", v_bit, 0);
    req(1);
    chk("R11 same-cycle frame1", cs_bit, 1);
    req(0);
    chk("R11 following frame0", cs_bit, 0);
    chk("R7 following v", v_bit, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_readback;
    t_lock;
    t_block(16'hDA5B);
    t_block(16'h154A);
    t_edges;
    t_shadow;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule